// File: doc/BRIEF.md
# Hazard Trip Latch with Recovery Policy

This block turns a set of clean digital hazard inputs into a held shutdown decision. Each input is classed at build time as hard or soft. A hard input forces the `kill` output high at once, through an asynchronous set path that needs no clock. `kill` then stays high until a recovery policy lets it go. Soft inputs drive `derate` and never drive `kill`. When a trip is latched, the block fixes a primary cause code, gathers any further hard causes as flags, and emits a one-cycle snapshot strobe. Surrounding logic uses that strobe to freeze its captured context.

Recovery is chosen by `reset_mode`. In manual mode an operator request releases the latch. In timed mode the block retries on its own, at most a fixed number of times, with a wait that doubles after each attempt. Once the retries are used up it accepts only an operator request. In two-step mode a request moves the block to a confirmation wait, and the latch opens only when `safe_confirm` is seen. Every attempt, whether requested or automatic, is first qualified. All interlock segments must have read closed, with no hard trip present, for `QUAL_TICKS` consecutive clocks. This count stands for the required closed time in milliseconds. A refused attempt reports a blocked code.

The control state machine has three states:
- ARMED: no trip is held. It moves to LATCHED on a synchronized hard trip, or on a latch rise whose cause has already vanished.
- LATCHED: a trip is held. In manual mode, or in timed mode once fallback applies, a qualified request moves it to ARMED (release). In timed mode a qualified automatic attempt moves it to ARMED. In two-step mode a qualified request moves it to CONFIRM.
- CONFIRM: `safe_confirm` moves it to ARMED (release). A returning hard trip moves it back to LATCHED.

Top module: `trip_latch_core`

## Requirements
- R1: A hard input (bits set in `HARD_MASK`, default inputs 0 to 2) drives `kill` high without waiting for any clock edge, even for a pulse shorter than one clock.
- R2: `kill` falls only in a cycle where the block releases. In manual mode a release happens only on the rising edge of `reset_req`.
- R3: In timed mode (`reset_mode`=1) the block makes at most `MAX_RETRY` automatic attempts. The first comes `BACKOFF_BASE` clocks after latching, and each later wait doubles. A successful automatic release does not restore the retry budget. With the budget spent, only a manual request can release. A request-based release restores the full budget.
- R4: In two-step mode (`reset_mode`=2) an accepted request does not clear `kill`. The release happens only once `safe_confirm` is high.
- R5: An attempt made before every segment has read closed, with no hard trip present, for `QUAL_TICKS` consecutive clocks is refused with `blocked_code`=2. `blocked_code` returns to 0 at release and at each new latch.
- R6: An attempt made while a hard input is still asserted is refused with `blocked_code`=1. `kill` stays high.
- R7: `reason_code` = index+1 of the earliest hard input seen. Inputs first seen in the same cycle resolve to the lowest index. A latch whose cause pulse was too short to be sampled reports code `N_TRIP`+1. Other hard inputs, present at the latch or arriving later, set their bits in `sec_flags`.
- R8: `snap_strobe` is high for exactly one cycle per latch, in the cycle the new `reason_code` appears. `reason_code` holds at all other times.
- R9: A soft input raises `derate` two clocks after it rises and leaves `kill` unaffected.
- R10: After reset, `kill`, `derate`, `reason_code`, `sec_flags`, `blocked_code` and both strobes read 0.
- R11: `release_strobe` is high for one cycle after each release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| trip_in | input | N_TRIP | Conditioned hazard inputs, active high |
| seg_closed | input | N_SEG | Interlock segment closed, one per segment |
| reset_req | input | 1 | Operator clear request, acts on its rising edge |
| safe_confirm | input | 1 | Energy-off confirmation for two-step recovery |
| reset_mode | input | 2 | 0 manual, 1 timed, 2 two-step (3 acts as manual) |
| kill | output | 1 | Hard shutdown output |
| derate | output | 1 | Soft derate output |
| reason_code | output | CODE_W | Primary cause of the last latch |
| sec_flags | output | N_TRIP | Secondary hard causes of the current episode |
| blocked_code | output | 2 | Cause of the last refused recovery attempt |
| snap_strobe | output | 1 | One-cycle pulse at latch time |
| release_strobe | output | 1 | One-cycle pulse after a release |

## Verification
The hardest situation to reach is a latch with no visible cause. This happens when a hard pulse falls between two clock edges, so the asynchronous latch holds it but the synchronizer never samples it. The stimulus raises and drops an input within half a clock period, and checks that `kill` is high before the next edge and that code `N_TRIP`+1 follows. Spending the timed retry budget is also awkward to reach. The bench holds one segment open through the whole doubling backoff, then confirms that only an operator request releases the latch.

// File: rtl/tl_pkg.sv
package tl_pkg;
    typedef enum logic [1:0] {
        ST_ARMED   = 2'd0,
        ST_LATCHED = 2'd1,
        ST_CONFIRM = 2'd2
    } tl_state_e;

    localparam logic [1:0] MODE_MANUAL = 2'd0;
    localparam logic [1:0] MODE_TIMED  = 2'd1;
    localparam logic [1:0] MODE_TWO    = 2'd2;

    localparam logic [1:0] BLK_NONE = 2'd0;
    localparam logic [1:0] BLK_TRIP = 2'd1;
    localparam logic [1:0] BLK_SEG  = 2'd2;
endpackage

// File: rtl/tl_sync.sv
module tl_sync #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    for (genvar i = 0; i < W; i++) begin : g_bit
        logic s1, s2;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                s1 <= 1'b0;
                s2 <= 1'b0;
            end else begin
                s1 <= d[i];
                s2 <= s1;
            end
        end
        assign q[i] = s2;
    end
endmodule

// File: rtl/tl_kill_latch.sv
module tl_kill_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic set_any,
    input  logic clr,
    output logic q
);
    // set dominates, acts without a clock edge
    always_ff @(posedge clk or posedge set_any or negedge rst_n) begin
        if (set_any)
            q <= 1'b1;
        else if (!rst_n)
            q <= 1'b0;
        else if (clr)
            q <= 1'b0;
    end
endmodule

// File: rtl/tl_qual_timer.sv
module tl_qual_timer #(
    parameter int QUAL_TICKS = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic quiet,
    output logic ready
);
    localparam int QW = $clog2(QUAL_TICKS + 1);
    logic [QW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt <= '0;
        else if (!quiet)
            cnt <= '0;
        else if (cnt != QW'(QUAL_TICKS))
            cnt <= cnt + 1'b1;
    end

    assign ready = (cnt == QW'(QUAL_TICKS));
endmodule

// File: rtl/tl_prio.sv
module tl_prio #(
    parameter int N      = 4,
    parameter int CODE_W = 3
) (
    input  logic [N-1:0]      vec,
    output logic [CODE_W-1:0] code,
    output logic [N-1:0]      onehot
);
    always_comb begin
        code   = '0;
        onehot = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (vec[i]) begin
                code      = CODE_W'(i + 1);
                onehot    = '0;
                onehot[i] = 1'b1;
            end
        end
    end
endmodule

// File: rtl/trip_latch_core.sv
module trip_latch_core
    import tl_pkg::*;
#(
    parameter int               N_TRIP       = 4,
    parameter int               N_SEG        = 3,
    parameter logic [N_TRIP-1:0] HARD_MASK   = 4'b0111,
    parameter int               QUAL_TICKS   = 8,
    parameter int               MAX_RETRY    = 3,
    parameter int               BACKOFF_BASE = 4,
    localparam int              CODE_W       = $clog2(N_TRIP + 2)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_TRIP-1:0] trip_in,
    input  logic [N_SEG-1:0]  seg_closed,
    input  logic              reset_req,
    input  logic              safe_confirm,
    input  logic [1:0]        reset_mode,
    output logic              kill,
    output logic              derate,
    output logic [CODE_W-1:0] reason_code,
    output logic [N_TRIP-1:0] sec_flags,
    output logic [1:0]        blocked_code,
    output logic              snap_strobe,
    output logic              release_strobe
);
    localparam int SW         = N_TRIP + N_SEG + 1;
    localparam int BO_MAX     = BACKOFF_BASE << MAX_RETRY;
    localparam int BO_W       = $clog2(BO_MAX + 1);
    localparam int RC_W       = $clog2(MAX_RETRY + 1);
    localparam logic [CODE_W-1:0] SHORT_CODE = CODE_W'(N_TRIP + 1);

    tl_state_e state, nxt;
    logic [SW-1:0] sync_q;
    logic [N_TRIP-1:0] trip_s, hard_s, soft_s, new_oh, prim_oh;
    logic [N_SEG-1:0] seg_s;
    logic [CODE_W-1:0] new_code;
    logic kill_q, kill_s2, kill_s3, kill_rise;
    logic trip_active, ready, req_q, req_rise, exhausted;
    logic go_latch, go_release, do_try, timed_try;
    logic [1:0] blk_now, fail_code;
    logic [BO_W-1:0] bo_cnt;
    logic [RC_W-1:0] retries;

    tl_sync #(.W(SW)) u_sync (
        .clk(clk), .rst_n(rst_n),
        .d({kill_q, seg_closed, trip_in}), .q(sync_q)
    );
    assign trip_s  = sync_q[N_TRIP-1:0];
    assign seg_s   = sync_q[N_TRIP +: N_SEG];
    assign kill_s2 = sync_q[SW-1];
    assign hard_s  = trip_s & HARD_MASK;
    assign soft_s  = trip_s & ~HARD_MASK;
    assign trip_active = |hard_s;
    assign kill_rise   = kill_s2 & ~kill_s3;
    assign req_rise    = reset_req & ~req_q;
    assign exhausted   = (retries == RC_W'(MAX_RETRY));

    tl_kill_latch u_latch (
        .clk(clk), .rst_n(rst_n),
        .set_any(|(trip_in & HARD_MASK)), .clr(go_release), .q(kill_q)
    );

    tl_qual_timer #(.QUAL_TICKS(QUAL_TICKS)) u_qual (
        .clk(clk), .rst_n(rst_n),
        .quiet((&seg_s) & ~trip_active), .ready(ready)
    );

    tl_prio #(.N(N_TRIP), .CODE_W(CODE_W)) u_prio (
        .vec(hard_s), .code(new_code), .onehot(new_oh)
    );

    for (genvar i = 0; i < N_TRIP; i++) begin : g_prim
        assign prim_oh[i] = (reason_code == CODE_W'(i + 1));
    end

    // next-state and transition decisions
    always_comb begin
        nxt        = state;
        go_latch   = 1'b0;
        go_release = 1'b0;
        do_try     = 1'b0;
        timed_try  = 1'b0;
        fail_code  = BLK_NONE;
        blk_now    = trip_active ? BLK_TRIP : (ready ? BLK_NONE : BLK_SEG);
        unique case (state)
            ST_ARMED: begin
                if (trip_active || kill_rise) begin
                    nxt      = ST_LATCHED;
                    go_latch = 1'b1;
                end
            end
            ST_LATCHED: begin
                if (reset_mode == MODE_TIMED && !exhausted) begin
                    if (bo_cnt == '0) begin
                        do_try    = 1'b1;
                        timed_try = 1'b1;
                    end
                end else if (req_rise) begin
                    do_try = 1'b1;
                end
                if (do_try) begin
                    if (blk_now != BLK_NONE) begin
                        fail_code = blk_now;
                    end else if (reset_mode == MODE_TWO && !timed_try) begin
                        nxt = ST_CONFIRM;
                    end else begin
                        nxt        = ST_ARMED;
                        go_release = 1'b1;
                    end
                end
            end
            ST_CONFIRM: begin
                if (trip_active) begin
                    nxt = ST_LATCHED;
                end else if (safe_confirm) begin
                    nxt        = ST_ARMED;
                    go_release = 1'b1;
                end
            end
            default: nxt = ST_ARMED;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_ARMED;
        else        state <= nxt;
    end

    // outputs and episode data
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            req_q          <= 1'b0;
            kill_s3        <= 1'b0;
            snap_strobe    <= 1'b0;
            release_strobe <= 1'b0;
            reason_code    <= '0;
            sec_flags      <= '0;
            blocked_code   <= BLK_NONE;
            bo_cnt         <= '0;
            retries        <= '0;
        end else begin
            req_q          <= reset_req;
            kill_s3        <= kill_s2;
            snap_strobe    <= go_latch;
            release_strobe <= go_release;
            if (go_latch) begin
                reason_code  <= trip_active ? new_code : SHORT_CODE;
                sec_flags    <= hard_s & ~new_oh;
                blocked_code <= BLK_NONE;
            end else begin
                if (state != ST_ARMED)
                    sec_flags <= sec_flags | (hard_s & ~prim_oh);
                if (fail_code != BLK_NONE)
                    blocked_code <= fail_code;
                else if (go_release)
                    blocked_code <= BLK_NONE;
            end
            if (go_latch)
                bo_cnt <= BO_W'(BACKOFF_BASE) << retries;
            else if (timed_try) begin
                if (fail_code != BLK_NONE)
                    bo_cnt <= BO_W'(BACKOFF_BASE) << (retries + 1'b1);
            end else if (state == ST_LATCHED && bo_cnt != '0)
                bo_cnt <= bo_cnt - 1'b1;
            if (timed_try)
                retries <= retries + 1'b1;
            else if (go_release)
                retries <= '0;
        end
    end

    assign kill   = kill_q;
    assign derate = |soft_s;
endmodule

// File: rtl/tl_checker.sv
module tl_checker #(
    parameter int CODE_W = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              kill,
    input logic              snap_strobe,
    input logic              release_strobe,
    input logic [CODE_W-1:0] reason_code,
    input logic [1:0]        blocked_code
);
    assert_snap_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
        snap_strobe |=> !snap_strobe);

    assert_reason_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !snap_strobe |-> $stable(reason_code));

    assert_kill_release_only_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(kill) |-> release_strobe);

    assert_release_clears_block_R5: assert property (@(posedge clk) disable iff (!rst_n)
        release_strobe |-> blocked_code == 2'd0);

    assert_release_single_R11: assert property (@(posedge clk) disable iff (!rst_n)
        release_strobe |=> !release_strobe);

    assert_block_legal_R6: assert property (@(posedge clk) disable iff (!rst_n)
        blocked_code != 2'd3);
endmodule

bind trip_latch_core tl_checker #(.CODE_W(CODE_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .kill(kill), .snap_strobe(snap_strobe),
    .release_strobe(release_strobe), .reason_code(reason_code),
    .blocked_code(blocked_code)
);

// File: tb/tb_trip_latch_core.sv
`timescale 1ns/1ps
module tb_trip_latch_core;
    localparam int NT = 4, NS = 3, QUAL = 8, MAXR = 3, BASE = 4;
    localparam int HARD = 4'b0111;
    localparam int CW = $clog2(NT + 2);

    logic clk = 1'b0, rst_n = 1'b0;
    logic [NT-1:0] trip_in = '0;
    logic [NS-1:0] seg_closed = '1;
    logic reset_req = 1'b0, safe_confirm = 1'b0;
    logic [1:0] reset_mode = 2'd0;
    logic kill, derate, snap_strobe, release_strobe;
    logic [CW-1:0] reason_code;
    logic [NT-1:0] sec_flags;
    logic [1:0] blocked_code;

    int tests = 0, fails = 0;

    always #2 clk = ~clk;

    trip_latch_core dut (
        .clk(clk), .rst_n(rst_n), .trip_in(trip_in), .seg_closed(seg_closed),
        .reset_req(reset_req), .safe_confirm(safe_confirm), .reset_mode(reset_mode),
        .kill(kill), .derate(derate), .reason_code(reason_code), .sec_flags(sec_flags),
        .blocked_code(blocked_code), .snap_strobe(snap_strobe),
        .release_strobe(release_strobe)
    );

    // behavioural reference model
    int m_t1, m_t2, m_g1, m_g2, m_k1, m_k2, m_k3, m_req, m_q;
    int m_st, m_reason, m_flags, m_blk, m_ret, m_bo, m_snap, m_rel, m_kill;

    task automatic model_reset();
        m_t1 = 0; m_t2 = 0; m_g1 = 0; m_g2 = 0; m_k1 = 0; m_k2 = 0; m_k3 = 0;
        m_req = 0; m_q = 0; m_st = 0; m_reason = 0; m_flags = 0; m_blk = 0;
        m_ret = 0; m_bo = 0; m_snap = 0; m_rel = 0; m_kill = 0;
    endtask

    task automatic model_step();
        int hard2, lowest, blk;
        bit active, rdy, rise, latch, rel, tried, timed, fail;
        hard2  = m_t2 & HARD;
        active = hard2 != 0;
        rdy    = m_q == QUAL;
        rise   = reset_req && !m_req;
        blk    = active ? 1 : (rdy ? 0 : 2);
        latch = 0; rel = 0; tried = 0; timed = 0; fail = 0;
        lowest = -1;
        for (int i = NT - 1; i >= 0; i--) if (hard2[i]) lowest = i;
        if (m_st == 0) begin
            if (active || (m_k2 && !m_k3)) latch = 1;
        end else if (m_st == 1) begin
            if (reset_mode == 1 && m_ret < MAXR) begin
                if (m_bo == 0) begin tried = 1; timed = 1; end
            end else if (rise) tried = 1;
            if (tried) begin
                if (blk != 0) fail = 1;
                else if (reset_mode == 2 && !timed) m_st = 2;
                else rel = 1;
            end
        end else begin
            if (active) m_st = 1;
            else if (safe_confirm) rel = 1;
        end
        if (latch) begin
            m_st = 1;
            m_reason = active ? lowest + 1 : NT + 1;
            m_flags = active ? (hard2 & ~(1 << lowest)) : 0;
            m_blk = 0;
            m_bo = BASE << m_ret;
        end else begin
            if (m_st != 0 || rel) begin
                if (m_reason >= 1 && m_reason <= NT) m_flags |= hard2 & ~(1 << (m_reason - 1));
                else m_flags |= hard2;
            end
            if (fail) m_blk = blk;
            else if (rel) m_blk = 0;
            if (timed) begin
                if (fail) m_bo = BASE << (m_ret + 1);
            end else if (m_st == 1 && m_bo != 0) m_bo--;
        end
        if (timed) m_ret++;
        else if (rel) m_ret = 0;
        if (rel) m_st = 0;
        m_snap = latch; m_rel = rel;
        if ((m_g2 != 7) || active) m_q = 0; else if (m_q < QUAL) m_q++;
        m_k3 = m_k2; m_k2 = m_k1; m_k1 = m_kill;
        m_t2 = m_t1; m_t1 = trip_in;
        m_g2 = m_g1; m_g1 = seg_closed;
        m_req = reset_req;
        if (rel) m_kill = ((trip_in & HARD) != 0);
    endtask

    always @(posedge clk) begin
        if (!rst_n) model_reset();
        else model_step();
    end

    task automatic chk(string tag, string what, int act, int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d at %0t", tag, what, act, exp, $time);
        end
    endtask

    // per-clock comparison against the model
    always @(negedge clk) begin
        if (rst_n) begin
            chk("R2", "kill", kill, m_kill);
            chk("R9", "derate", derate, (m_t2 & ~HARD & 15) != 0);
            chk("R7", "reason_code", reason_code, m_reason);
            chk("R7", "sec_flags", sec_flags, m_flags);
            chk("R5", "blocked_code", blocked_code, m_blk);
            chk("R8", "snap_strobe", snap_strobe, m_snap);
            chk("R11", "release_strobe", release_strobe, m_rel);
        end
    end

    task automatic tick(int n = 1);
        repeat (n) @(negedge clk);
        #0.5;
    endtask

    task automatic set_trip(logic [NT-1:0] v);
        trip_in = v;
        if ((v & HARD) != 0) m_kill = 1;
    endtask

    task automatic request();
        reset_req = 1'b1; tick(); reset_req = 1'b0;
    endtask

    initial begin
        #800000;
        fails++;
        $display("FAIL watchdog expired");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        model_reset();
        tick(5);
        rst_n = 1'b1;
        tick();
        chk("R10", "kill after reset", kill, 0);
        chk("R10", "reason after reset", reason_code, 0);
        chk("R10", "blocked after reset", blocked_code, 0);
        tick(12);

        // soft input: derate only
        set_trip(4'b1000); tick(4);
        chk("R9", "derate on soft", derate, 1);
        chk("R9", "kill on soft", kill, 0);
        set_trip(4'b0000); tick(4);

        // earliest hard input wins; async set
        set_trip(4'b0100); #0.2;
        chk("R1", "kill before edge", kill, 1);
        tick(2);
        set_trip(4'b0101); tick(4);
        chk("R7", "earliest reason", reason_code, 3);
        chk("R7", "later flag", sec_flags, 4'b0001);
        request(); tick(2);
        chk("R6", "blocked while active", blocked_code, 1);
        chk("R6", "kill held", kill, 1);
        set_trip(4'b0000); tick(3);
        request(); tick(2);
        chk("R5", "blocked unqualified", blocked_code, 2);
        chk("R2", "kill held unqualified", kill, 1);
        tick(12);
        request(); tick(2);
        chk("R2", "manual release", kill, 0);

        // simultaneous causes
        set_trip(4'b0110); tick(4);
        chk("R7", "tie reason", reason_code, 2);
        chk("R7", "tie flags", sec_flags, 4'b0100);
        set_trip(4'b0000); tick(14); request(); tick(3);
        chk("R2", "released after tie", kill, 0);

        // sub-cycle pulse
        set_trip(4'b0001); #0.4; trip_in = '0; #0.1;
        chk("R1", "short pulse latched", kill, 1);
        tick(4);
        chk("R7", "short pulse code", reason_code, NT + 1);
        tick(12); request(); tick(3);

        // two-step
        reset_mode = 2'd2;
        set_trip(4'b0001); tick(3); set_trip(4'b0000); tick(14);
        request(); tick(6);
        chk("R4", "held after request", kill, 1);
        safe_confirm = 1'b1; tick(2);
        chk("R4", "released on confirm", kill, 0);
        safe_confirm = 1'b0; tick(3);

        // timed: exhaust budget with a segment open
        reset_mode = 2'd1;
        seg_closed = 3'b011;
        set_trip(4'b0010); tick(3); set_trip(4'b0000); tick(80);
        chk("R3", "exhausted still latched", kill, 1);
        chk("R3", "exhausted blocked", blocked_code, 2);
        seg_closed = 3'b111; tick(14);
        chk("R3", "no retry after budget", kill, 1);
        request(); tick(2);
        chk("R3", "manual fallback release", kill, 0);

        // timed: automatic success
        set_trip(4'b0001); tick(3); set_trip(4'b0000); tick(40);
        chk("R3", "automatic release", kill, 0);
        tick(5);

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule